// File: doc/BRIEF.md
# Bus Address Decoder with Configuration Registers

This block is the decode stage that sits behind one master port of a multi-master, multi-slave interconnect. It looks at the master's request address and raises one bit of a slave select vector, chosen directly by the top address nibble. A reserved region, identified by the top address byte reading 0xFF, is not passed to any slave. Requests to that region are answered locally by a small register file.

The register file holds sixteen 32-bit words, one every four bytes. Word 0 carries the packed arbitration priorities, two bits per master, and this field is exported to the arbiters. The remaining words are plain storage.

Register accesses use a simple cycle/strobe handshake. The acknowledge arrives one clock after the strobe. Writes are masked per byte lane by the select field.

Top module: `bus_addr_decode`

## Requirements
- R1: While `req_cyc` and `req_stb` are both high and the address is outside the register region, `slv_sel` is one-hot, with bit k set when `req_adr[31:28]` equals k, for k from 0 to NUM_SLV-1 (8 by default).
- R2: A top nibble of NUM_SLV or above (8 to 15 by default) that is outside the register region selects no slave.
- R3: An address with `req_adr[31:24]` equal to 0xFF belongs to the register region. This takes precedence over slave decode: `slv_sel` is all zeros and no slave sees the request.
- R4: A register-region request is acknowledged by a single-cycle `cfg_ack` pulse in the clock after the strobe is first seen. Requests outside the region are never acknowledged.
- R5: The register index is `req_adr[5:2]`. A write to register n reads back unchanged through a later read of register n.
- R6: A write updates byte lane b (bits 8b+7..8b) only when `req_sel[b]` is 1. All other lanes keep their previous value.
- R7: After reset, all registers are zero, `prio_word` is zero and `cfg_ack` is low.
- R8: `prio_word` equals bits [15:0] of register 0. Master m's priority sits in bits [2m+1:2m].
- R9: Writes to registers 1 to 15 leave `prio_word` unchanged.
- R10: With `req_cyc` or `req_stb` low, `slv_sel` is all zeros and no acknowledge is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_cyc | input | 1 | Master bus cycle in progress |
| req_stb | input | 1 | Master strobe |
| req_we | input | 1 | Write when high, read when low |
| req_sel | input | 4 | Byte lane enables for writes |
| req_adr | input | 32 | Request byte address |
| req_wdat | input | 32 | Write data |
| cfg_ack | output | 1 | Acknowledge for register-region accesses |
| cfg_rdat | output | 32 | Register read data, valid with `cfg_ack` on reads |
| slv_sel | output | 8 | One-hot slave select |
| prio_word | output | 16 | Packed per-master priorities, 2 bits per master |

## Verification
The decode is driven with every top nibble from 0 to 15 outside the register region. This separates the eight selecting codes from the eight non-selecting ones.

Addresses of the form 0xFFxx_xxxx are tried next. Because their top nibble is 0xF, they show whether the register region really overrides the plain nibble decode. The same patterns are repeated with the cycle or strobe low, to show that the select is gated by the handshake.

On the register side, each of the sixteen words is written with a distinct pattern and read back, which exposes any index aliasing. Partial byte masks tell the lane gating apart from a full-word write. Writes to words 1 to 15 are interleaved with checks of `prio_word`, which separates the priority register from general storage.

// File: rtl/bus_addr_decode_pkg.sv
package bus_addr_decode_pkg;

   // Classification of the current request
   typedef enum logic [1:0] {
      ROUTE_IDLE  = 2'd0,  // no cycle/strobe
      ROUTE_SLAVE = 2'd1,  // to an existing slave port
      ROUTE_CFG   = 2'd2,  // to the local register file
      ROUTE_NONE  = 2'd3   // nibble beyond the populated slaves
   } route_e;

endpackage

// File: rtl/bad_region.sv
module bad_region
   import bus_addr_decode_pkg::*;
#(
   parameter int ADR_W     = 32,
   parameter int SLV_IDX_W = 4,
   parameter int NUM_SLV   = 8,
   parameter int TAG_W     = 8,
   parameter logic [TAG_W-1:0] CFG_TAG = 8'hFF
) (
   input  logic                 act,
   input  logic [ADR_W-1:0]     adr,
   output route_e               route,
   output logic [SLV_IDX_W-1:0] slv_idx
);
   localparam logic [SLV_IDX_W:0] SLV_LIM = (SLV_IDX_W+1)'(NUM_SLV);

   logic tag_hit;
   assign slv_idx = adr[ADR_W-1 -: SLV_IDX_W];
   assign tag_hit = (adr[ADR_W-1 -: TAG_W] == CFG_TAG);

   always_comb begin
      if (!act)                          route = ROUTE_IDLE;
      else if (tag_hit)                  route = ROUTE_CFG;
      else if ({1'b0, slv_idx} < SLV_LIM) route = ROUTE_SLAVE;
      else                               route = ROUTE_NONE;
   end
endmodule

// File: rtl/bad_slave_sel.sv
module bad_slave_sel
   import bus_addr_decode_pkg::*;
#(
   parameter int SLV_IDX_W = 4,
   parameter int NUM_SLV   = 8
) (
   input  route_e               route,
   input  logic [SLV_IDX_W-1:0] slv_idx,
   output logic [NUM_SLV-1:0]   slv_sel
);
   for (genvar s = 0; s < NUM_SLV; s++) begin : g_sel
      assign slv_sel[s] = (route == ROUTE_SLAVE) && (slv_idx == SLV_IDX_W'(s));
   end
endmodule

// File: rtl/bad_cfg_regs.sv
module bad_cfg_regs #(
   parameter int DAT_W   = 32,
   parameter int REG_CNT = 16,
   parameter int MST_CNT = 8,
   parameter int PRIO_W  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        acc,
   input  logic                        we,
   input  logic [DAT_W/8-1:0]          sel,
   input  logic [$clog2(REG_CNT)-1:0]  ridx,
   input  logic [DAT_W-1:0]            wdat,
   output logic                        ack,
   output logic [DAT_W-1:0]            rdat,
   output logic [MST_CNT*PRIO_W-1:0]   prio
);
   localparam int SEL_W = DAT_W / 8;

   logic [DAT_W-1:0] regs [REG_CNT];
   logic             start;

   // a new access is taken once, in the cycle before its acknowledge
   assign start = acc && !ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack  <= 1'b0;
         rdat <= '0;
         for (int r = 0; r < REG_CNT; r++) regs[r] <= '0;
      end else begin
         ack <= start;
         if (start) begin
            rdat <= regs[ridx];
            if (we) begin
               for (int b = 0; b < SEL_W; b++) begin
                  if (sel[b]) regs[ridx][8*b +: 8] <= wdat[8*b +: 8];
               end
            end
         end
      end
   end

   // priority fields exported from word 0
   for (genvar m = 0; m < MST_CNT; m++) begin : g_prio
      assign prio[m*PRIO_W +: PRIO_W] = regs[0][m*PRIO_W +: PRIO_W];
   end
endmodule

// File: rtl/bus_addr_decode.sv
module bus_addr_decode
   import bus_addr_decode_pkg::*;
#(
   parameter int ADR_W     = 32,
   parameter int DAT_W     = 32,
   parameter int SLV_IDX_W = 4,
   parameter int NUM_SLV   = 8,
   parameter int REG_CNT   = 16,
   parameter int MST_CNT   = 8,
   parameter int PRIO_W    = 2,
   parameter int TAG_W     = 8,
   parameter logic [TAG_W-1:0] CFG_TAG = 8'hFF
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_cyc,
   input  logic                      req_stb,
   input  logic                      req_we,
   input  logic [DAT_W/8-1:0]        req_sel,
   input  logic [ADR_W-1:0]          req_adr,
   input  logic [DAT_W-1:0]          req_wdat,
   output logic                      cfg_ack,
   output logic [DAT_W-1:0]          cfg_rdat,
   output logic [NUM_SLV-1:0]        slv_sel,
   output logic [MST_CNT*PRIO_W-1:0] prio_word
);
   localparam int REG_AW = $clog2(REG_CNT);

   // elaboration-time parameter checks
   if (DAT_W % 8 != 0) begin : g_bad_dat
      $error("DAT_W must be a whole number of bytes");
   end
   if (NUM_SLV > (1 << SLV_IDX_W)) begin : g_bad_slv
      $error("NUM_SLV exceeds the reach of SLV_IDX_W");
   end
   if ((1 << REG_AW) != REG_CNT) begin : g_bad_reg
      $error("REG_CNT must be a power of two");
   end
   if (MST_CNT * PRIO_W > DAT_W) begin : g_bad_prio
      $error("priority fields do not fit one register");
   end
   if (TAG_W < SLV_IDX_W || REG_AW + 2 > ADR_W - TAG_W) begin : g_bad_adr
      $error("address fields overlap");
   end

   route_e               route;
   logic [SLV_IDX_W-1:0] slv_idx;

   bad_region #(
      .ADR_W(ADR_W), .SLV_IDX_W(SLV_IDX_W), .NUM_SLV(NUM_SLV),
      .TAG_W(TAG_W), .CFG_TAG(CFG_TAG)
   ) u_region (
      .act     (req_cyc && req_stb),
      .adr     (req_adr),
      .route   (route),
      .slv_idx (slv_idx)
   );

   bad_slave_sel #(
      .SLV_IDX_W(SLV_IDX_W), .NUM_SLV(NUM_SLV)
   ) u_sel (
      .route   (route),
      .slv_idx (slv_idx),
      .slv_sel (slv_sel)
   );

   bad_cfg_regs #(
      .DAT_W(DAT_W), .REG_CNT(REG_CNT), .MST_CNT(MST_CNT), .PRIO_W(PRIO_W)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (route == ROUTE_CFG),
      .we    (req_we),
      .sel   (req_sel),
      .ridx  (req_adr[REG_AW+1:2]),
      .wdat  (req_wdat),
      .ack   (cfg_ack),
      .rdat  (cfg_rdat),
      .prio  (prio_word)
   );
endmodule

// File: rtl/bus_addr_decode_chk.sv
module bus_addr_decode_chk #(
   parameter int ADR_W   = 32,
   parameter int NUM_SLV = 8,
   parameter int REG_CNT = 16,
   parameter int PRIO_BITS = 16,
   parameter int TAG_W   = 8,
   parameter logic [TAG_W-1:0] CFG_TAG = 8'hFF
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_cyc,
   input logic                 req_stb,
   input logic                 req_we,
   input logic [ADR_W-1:0]     req_adr,
   input logic                 cfg_ack,
   input logic [NUM_SLV-1:0]   slv_sel,
   input logic [PRIO_BITS-1:0] prio_word
);
   localparam int REG_AW = $clog2(REG_CNT);

   logic act, in_cfg, wr_reg0;
   assign act     = req_cyc && req_stb;
   assign in_cfg  = req_adr[ADR_W-1 -: TAG_W] == CFG_TAG;
   assign wr_reg0 = act && req_we && in_cfg && (req_adr[REG_AW+1:2] == '0);

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slv_sel));                                       // R1
   AST_CFG_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      act && in_cfg |-> slv_sel == '0);                         // R3
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ack |=> !cfg_ack);                                    // R4
   AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ack |-> $past(act && in_cfg));                        // R4
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> slv_sel == '0);                                  // R10
   AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_reg0) |-> $stable(prio_word));                  // R9
endmodule

bind bus_addr_decode bus_addr_decode_chk #(
   .ADR_W(ADR_W), .NUM_SLV(NUM_SLV), .REG_CNT(REG_CNT),
   .PRIO_BITS(MST_CNT*PRIO_W), .TAG_W(TAG_W), .CFG_TAG(CFG_TAG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_cyc   (req_cyc),
   .req_stb   (req_stb),
   .req_we    (req_we),
   .req_adr   (req_adr),
   .cfg_ack   (cfg_ack),
   .slv_sel   (slv_sel),
   .prio_word (prio_word)
);

// File: tb/sim_bus_addr_decode.sv
module sim_bus_addr_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_cyc = 1'b0, req_stb = 1'b0, req_we = 1'b0;
   logic [3:0]  req_sel = 4'h0;
   logic [31:0] req_adr = '0, req_wdat = '0;
   logic        cfg_ack;
   logic [31:0] cfg_rdat;
   logic [7:0]  slv_sel;
   logic [15:0] prio_word;

   int n_chk = 0, n_err = 0;
   logic [31:0] rd_val;

   always #2 clk = ~clk;   // 250 MHz

   bus_addr_decode u0 (
      .clk(clk), .rst_n(rst_n), .req_cyc(req_cyc), .req_stb(req_stb),
      .req_we(req_we), .req_sel(req_sel), .req_adr(req_adr),
      .req_wdat(req_wdat), .cfg_ack(cfg_ack), .cfg_rdat(cfg_rdat),
      .slv_sel(slv_sel), .prio_word(prio_word)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // one register access; checks ack timing on the way
   task automatic cfg_acc(input logic we, input logic [3:0] idx,
                          input logic [3:0] sel, input logic [31:0] wd,
                          output logic [31:0] rd);
      @(negedge clk);
      req_cyc = 1; req_stb = 1; req_we = we; req_sel = sel;
      req_adr = 32'hFF00_0000 | {26'd0, idx, 2'b00}; req_wdat = wd;
      #1 chk("R3 select off in region", {24'd0, slv_sel}, 32'd0);
      chk("R4 no ack before edge", {31'd0, cfg_ack}, 32'd0);
      @(posedge clk); #1;
      chk("R4 ack one cycle after stb", {31'd0, cfg_ack}, 32'd1);
      rd = cfg_rdat;
      @(negedge clk);
      req_cyc = 0; req_stb = 0; req_we = 0;
      @(posedge clk); #1;
      chk("R4 ack is one pulse", {31'd0, cfg_ack}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R7 ack low in reset", {31'd0, cfg_ack}, 32'd0);
      chk("R7 prio zero in reset", {16'd0, prio_word}, 32'd0);
      for (int r = 0; r < 16; r++) begin
         cfg_acc(0, 4'(r), 4'hF, 0, rd_val);
         chk("R7 register zero after reset", rd_val, 32'd0);
      end
   endtask

   task automatic t_slave_decode;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         req_cyc = 1; req_stb = 1; req_adr = {4'(k), 28'h0123450};
         #1;
         if (k < 8) chk("R1 one-hot nibble decode", {24'd0, slv_sel}, 32'd1 << k);
         else       chk("R2 unpopulated nibble", {24'd0, slv_sel}, 32'd0);
         @(posedge clk); #1;
         chk("R4 no ack outside region", {31'd0, cfg_ack}, 32'd0);
      end
      @(negedge clk); req_cyc = 0; req_stb = 0;
   endtask

   task automatic t_idle;
      @(negedge clk);
      req_cyc = 1; req_stb = 0; req_adr = 32'h3000_0000;
      #1 chk("R10 strobe low", {24'd0, slv_sel}, 32'd0);
      req_cyc = 0; req_stb = 1;
      #1 chk("R10 cycle low", {24'd0, slv_sel}, 32'd0);
      req_adr = 32'hFF00_0000;
      @(posedge clk); #1 chk("R10 no ack without cycle", {31'd0, cfg_ack}, 32'd0);
      @(negedge clk); req_stb = 0;
   endtask

   task automatic t_precedence;
      @(negedge clk);
      req_cyc = 1; req_stb = 1; req_adr = 32'hFF12_3404;
      #1 chk("R3 region overrides nibble 15", {24'd0, slv_sel}, 32'd0);
      req_adr = 32'hFE00_0000;
      #1 chk("R2 0xFE not region, nibble 15", {24'd0, slv_sel}, 32'd0);
      req_adr = 32'h0F00_0000;
      #1 chk("R1 0x0F selects slave 0", {24'd0, slv_sel}, 32'd1);
      req_cyc = 0; req_stb = 0;
   endtask

   task automatic t_readback;
      for (int r = 0; r < 16; r++)
         cfg_acc(1, 4'(r), 4'hF, 32'hA500_0000 ^ (32'(r) * 32'h0101_1357), rd_val);
      for (int r = 0; r < 16; r++) begin
         cfg_acc(0, 4'(r), 4'hF, 0, rd_val);
         chk("R5 read back by index", rd_val, 32'hA500_0000 ^ (32'(r) * 32'h0101_1357));
      end
   endtask

   task automatic t_bytes;
      cfg_acc(1, 4'd5, 4'hF, 32'hFFFF_FFFF, rd_val);
      cfg_acc(1, 4'd5, 4'b0101, 32'h1234_5678, rd_val);
      cfg_acc(0, 4'd5, 4'hF, 0, rd_val);
      chk("R6 lanes 0 and 2 only", rd_val, 32'hFF34_FF78);
      cfg_acc(1, 4'd5, 4'b0000, 32'h0, rd_val);
      cfg_acc(0, 4'd5, 4'hF, 0, rd_val);
      chk("R6 empty mask keeps word", rd_val, 32'hFF34_FF78);
   endtask

   task automatic t_prio;
      logic [15:0] pv;
      pv = 16'b11_01_10_11_00_01_00_10;
      cfg_acc(1, 4'd0, 4'hF, {16'hBEEF, pv}, rd_val);
      chk("R8 prio word from register 0", {16'd0, prio_word}, {16'd0, pv});
      for (int m = 0; m < 8; m++)
         chk("R8 master field position", {30'd0, prio_word[2*m +: 2]}, {30'd0, 2'(pv >> (2*m))});
      for (int r = 1; r < 16; r++) begin
         cfg_acc(1, 4'(r), 4'hF, 32'h0000_5A5A, rd_val);
         chk("R9 other register leaves prio", {16'd0, prio_word}, {16'd0, pv});
      end
      cfg_acc(1, 4'd0, 4'b0001, 32'h0000_0000, rd_val);
      chk("R8 low byte write", {16'd0, prio_word}, {16'd0, pv[15:8], 8'h00});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset_quick();
      rst_n = 1'b1;
      t_reset;
      t_slave_decode;
      t_idle;
      t_precedence;
      t_readback;
      t_bytes;
      t_prio;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   task automatic t_reset_quick;
      chk("R7 ack low during reset", {31'd0, cfg_ack}, 32'd0);
      chk("R7 prio zero during reset", {16'd0, prio_word}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule